// File: doc/BRIEF.md
# Two-Dimensional DMA Word Address Generator

This block is the address and sequencing engine of one DMA channel. Software programs a start word address, a line length, a line pitch and a line count, all counted in 32-bit words, and then pulses `start`. That pulse stands for the final programming write: the size, pitch and control fields are set up beforehand. The engine then offers one word address at a time on a request/grant handshake toward a memory port. The address moves on only in cycles where the grant is high. The word address is the byte address shifted right by two. The live address is always visible on `cur_addr`, so software can work out the bytes still to go from the programmed size and the distance travelled.

With a non-zero line length the engine walks a rectangle and then signals completion. With a line length of zero it becomes a ring buffer that never ends on its own. The ring spans `pitch × (count + 1)` words. The engine wraps back to the start address and raises one event at the end of each half of the ring. Ring traffic runs only while both loop-enable bits are set. Clearing either bit pauses the ring, and setting both again resumes it. An abort returns the engine to idle from either mode.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous active-low reset the engine is idle: `req_valid`, `busy`, `done`, `half_evt` and `wrap_evt` are 0 and `cur_addr` is 0.
- R2: A `start` pulse while idle captures the configuration. In the next cycle `busy` and `req_valid` are 1 and `req_addr` equals the start address.
- R3: With a non-zero line length L, pitch P and count N, the engine requests L×(N+1) words. Word k has address start + (k / L)×P + (k mod L).
- R4: The request address changes only after a cycle in which `req_valid` and `req_grant` are both high. Otherwise it holds.
- R5: In the cycle after the final word is granted, `done` is 1 for exactly one cycle and `busy` is 0. `cur_addr` then keeps the address of the final word.
- R6: A line length of 0 selects ring mode. Word k has address start + (k mod A), with A = P×(N+1), and `done` never rises.
- R7: In ring mode, `half_evt` pulses for one cycle after the word at ring offset floor(A/2)−1 is granted. `wrap_evt` pulses for one cycle after the word at offset A−1 is granted.
- R8: In ring mode `req_valid` is 0 unless both bits of `loop_en` are 1. While paused, grants are ignored and the address holds. Restoring both bits resumes from the held address.
- R9: `abort` makes the engine idle in the next cycle without a `done` pulse. It takes priority over a grant in the same cycle, and a later `start` works normally.
- R10: `req_burst` and `req_dir` carry the values of `cfg_burst4` (control bit 4: 1 = four-word bursts) and `cfg_dir` (control bit 5: transfer direction) captured at `start`.
- R11: A `start` pulse while busy is ignored and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 32 | Start word address |
| cfg_line_len | input | 16 | Words per line; 0 selects ring mode |
| cfg_pitch | input | 16 | Words between consecutive line starts |
| cfg_lines | input | 16 | Number of lines minus one |
| cfg_burst4 | input | 1 | Control bit 4: four-word burst mode |
| cfg_dir | input | 1 | Control bit 5: transfer direction |
| start | input | 1 | Start pulse, honoured only while idle |
| abort | input | 1 | Return to idle at once |
| loop_en | input | 2 | Ring enable pair; both bits needed to run |
| req_valid | output | 1 | A word request is offered |
| req_addr | output | 32 | Word address of the offered request |
| req_burst | output | 1 | Captured burst-mode bit |
| req_dir | output | 1 | Captured direction bit |
| req_grant | input | 1 | Memory port accepts the offered word |
| cur_addr | output | 32 | Live current word address |
| busy | output | 1 | A transfer or ring is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| half_evt | output | 1 | One-cycle end-of-first-half ring event |
| wrap_evt | output | 1 | One-cycle end-of-ring event |

## Verification
The embedded properties check the following on every cycle:
- the address holds when no grant is accepted, including while the ring is paused;
- `done` lasts one cycle and coincides with idle;
- abort leads to idle with no `done`;
- the two ring events never coincide;
- ring mode never raises `done`;
- the column and ring-offset counters stay inside their programmed bounds.

Only the directed scenarios can show the exact address sequence, the line stepping by the pitch, and the position of the half and wrap events. The same holds for the captured control bits, the ignored restart while busy, and the resume point after a pause.

// File: rtl/dma2d_pkg.sv
// Shared definitions for the two-dimensional DMA address generator.
// Assumes nothing beyond a single clock domain.
package dma2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINE = 2'd1,
        ST_RING = 2'd2
    } walk_state_t;
endpackage

// File: rtl/dma2d_line_walker.sv
// Rectangle walker: produces the word address of the current beat of a
// line-by-line transfer and flags the final beat.
// Assumes the length captured at load is non-zero and that step is only
// raised while the owner is in line mode.
module dma2d_line_walker #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          active,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [LW-1:0] pitch,
    input  logic [CW-1:0] lines,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] row_base;
    logic [LW-1:0] col;
    logic [CW-1:0] row;
    logic [LW-1:0] len_q;
    logic [LW-1:0] pitch_q;
    logic [CW-1:0] lines_q;
    logic          end_of_row;

    assign end_of_row = (col == len_q - LW'(1));
    assign last       = end_of_row && (row == lines_q);
    assign addr       = row_base + AW'(col);

    // Capture geometry at load; advance column, then row, per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= '0;
            col      <= '0;
            row      <= '0;
            len_q    <= '0;
            pitch_q  <= '0;
            lines_q  <= '0;
        end else if (load) begin
            row_base <= base;
            col      <= '0;
            row      <= '0;
            len_q    <= len;
            pitch_q  <= pitch;
            lines_q  <= lines;
        end else if (step && !last) begin
            if (end_of_row) begin
                col      <= '0;
                row      <= row + CW'(1);
                row_base <= row_base + AW'(pitch_q);
            end else begin
                col <= col + LW'(1);
            end
        end
    end

    // R3: the column stays inside the programmed line while walking.
    p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (col < len_q));
endmodule

// File: rtl/dma2d_ring_walker.sv
// Ring walker: produces the word address inside a wrapping area of
// pitch*(lines+1) words and flags the last word of each half.
// Assumes the area is at least two words while active.
module dma2d_ring_walker #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          active,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] pitch,
    input  logic [CW-1:0] lines,
    output logic [AW-1:0] addr,
    output logic          half_hit,
    output logic          wrap_hit
);
    localparam int AREA_W = LW + CW;

    logic [AW-1:0]     base_q;
    logic [AREA_W-1:0] area_q;
    logic [AREA_W-1:0] half_q;
    logic [AREA_W-1:0] pos;

    assign addr     = base_q + AW'(pos);
    assign wrap_hit = (pos == area_q - AREA_W'(1));
    assign half_hit = (half_q != '0) && (pos == half_q - AREA_W'(1));

    // Capture area size at load; step the offset and wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            area_q <= '0;
            half_q <= '0;
            pos    <= '0;
        end else if (load) begin
            base_q <= base;
            area_q <= AREA_W'(pitch) * (AREA_W'(lines) + AREA_W'(1));
            half_q <= (AREA_W'(pitch) * (AREA_W'(lines) + AREA_W'(1))) >> 1;
            pos    <= '0;
        end else if (step) begin
            pos <= wrap_hit ? '0 : pos + AREA_W'(1);
        end
    end

    // R6: the ring offset never leaves the programmed area.
    p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pos < area_q));
endmodule

// File: rtl/dma2d_addr_gen.sv
// Top of the per-channel 2-D DMA address generator. Selects rectangle or
// ring mode at start, offers one word request per cycle on a request/grant
// handshake, and raises done or half/wrap events.
// Assumes a single requester per channel and a grant that is only
// meaningful while req_valid is high.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_line_len,
    input  logic [LW-1:0] cfg_pitch,
    input  logic [CW-1:0] cfg_lines,
    input  logic          cfg_burst4,
    input  logic          cfg_dir,
    input  logic          start,
    input  logic          abort,
    input  logic [1:0]    loop_en,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_burst,
    output logic          req_dir,
    input  logic          req_grant,
    output logic [AW-1:0] cur_addr,
    output logic          busy,
    output logic          done,
    output logic          half_evt,
    output logic          wrap_evt
);
    walk_state_t   state;
    logic          ring_mode_q;
    logic          start_ok;
    logic          line_load;
    logic          ring_load;
    logic          beat;
    logic          line_step;
    logic          ring_step;
    logic [AW-1:0] line_addr;
    logic [AW-1:0] ring_addr;
    logic          line_last;
    logic          ring_half;
    logic          ring_wrap;

    assign start_ok  = start && (state == ST_IDLE) && !abort;
    assign line_load = start_ok && (cfg_line_len != '0);
    assign ring_load = start_ok && (cfg_line_len == '0);
    assign req_valid = (state == ST_LINE) ||
                       ((state == ST_RING) && (loop_en == 2'b11));
    assign beat      = req_valid && req_grant && !abort;
    assign line_step = beat && (state == ST_LINE);
    assign ring_step = beat && (state == ST_RING);
    assign cur_addr  = ring_mode_q ? ring_addr : line_addr;
    assign req_addr  = cur_addr;
    assign busy      = (state != ST_IDLE);

    dma2d_line_walker #(.AW(AW), .LW(LW), .CW(CW)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (line_load),
        .step   (line_step),
        .active (state == ST_LINE),
        .base   (cfg_base),
        .len    (cfg_line_len),
        .pitch  (cfg_pitch),
        .lines  (cfg_lines),
        .addr   (line_addr),
        .last   (line_last)
    );

    dma2d_ring_walker #(.AW(AW), .LW(LW), .CW(CW)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ring_load),
        .step     (ring_step),
        .active   (state == ST_RING),
        .base     (cfg_base),
        .pitch    (cfg_pitch),
        .lines    (cfg_lines),
        .addr     (ring_addr),
        .half_hit (ring_half),
        .wrap_hit (ring_wrap)
    );

    // Mode sequencing: abort first, then start from idle, then completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (abort) begin
            state <= ST_IDLE;
        end else if (start_ok) begin
            state <= line_load ? ST_LINE : ST_RING;
        end else if (line_step && line_last) begin
            state <= ST_IDLE;
        end
    end

    // Capture mode and control bits when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_mode_q <= 1'b0;
            req_burst   <= 1'b0;
            req_dir     <= 1'b0;
        end else if (start_ok) begin
            ring_mode_q <= ring_load;
            req_burst   <= cfg_burst4;
            req_dir     <= cfg_dir;
        end
    end

    // One-cycle completion and ring event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            half_evt <= 1'b0;
            wrap_evt <= 1'b0;
        end else begin
            done     <= line_step && line_last;
            half_evt <= ring_step && ring_half;
            wrap_evt <= ring_step && ring_wrap;
        end
    end

    // R4: no accepted beat while busy means the address holds.
    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(req_valid && req_grant) && !abort) |=> $stable(cur_addr));
    // R5: done lasts a single cycle.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: done coincides with idle.
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: ring mode never completes.
    p_ring_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RING) |=> !done);
    // R7: the two ring events never fire together.
    p_evt_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(half_evt && wrap_evt));
    // R8: a paused ring holds its address.
    p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RING) && (loop_en != 2'b11) && !abort) |=> $stable(cur_addr));
    // R9: abort ends in idle with no done.
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !done));
endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_line_len = '0;
    logic [15:0] cfg_pitch = '0;
    logic [15:0] cfg_lines = '0;
    logic        cfg_burst4 = 1'b0;
    logic        cfg_dir = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [1:0]  loop_en = 2'b11;
    logic        req_grant = 1'b0;
    logic        req_valid, req_burst, req_dir, busy, done, half_evt, wrap_evt;
    logic [31:0] req_addr, cur_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma2d_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_line_len(cfg_line_len),
        .cfg_pitch(cfg_pitch), .cfg_lines(cfg_lines), .cfg_burst4(cfg_burst4),
        .cfg_dir(cfg_dir), .start(start), .abort(abort), .loop_en(loop_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_burst(req_burst),
        .req_dir(req_dir), .req_grant(req_grant), .cur_addr(cur_addr),
        .busy(busy), .done(done), .half_evt(half_evt), .wrap_evt(wrap_evt)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] b, input int len, input int p, input int n,
                          input bit bst, input bit dr);
        @(negedge clk);
        cfg_base = b; cfg_line_len = 16'(len); cfg_pitch = 16'(p); cfg_lines = 16'(n);
        cfg_burst4 = bst; cfg_dir = dr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && req_valid, "R2 busy/valid after start", {busy, req_valid}, 2'b11);
        chk(req_addr == b, "R2 first address", req_addr, b);
    endtask

    task automatic t_reset();
        chk(!req_valid && !busy && !done && !half_evt && !wrap_evt, "R1 idle outputs",
            {req_valid, busy, done, half_evt, wrap_evt}, 0);
        chk(cur_addr == 0, "R1 cur_addr", cur_addr, 0);
    endtask

    task automatic t_rect(input logic [31:0] b, input int len, input int p, input int n,
                          input bit bst, input bit dr, input bit alt, input bit poke);
        int total = len * (n + 1);
        int k = 0;
        int cyc = 0;
        longint e = 0;
        launch(b, len, p, n, bst, dr);
        chk(req_burst == bst && req_dir == dr, "R10 control bits", {req_burst, req_dir}, {bst, dr});
        while (k < total && cyc < 2000) begin
            bit g = alt ? (cyc % 2 == 0) : 1'b1;
            e = b + (k / len) * p + (k % len);
            chk(req_valid && req_addr == e, "R3 R4 R11 address", req_addr, e);
            chk(!done, "R5 no early done", done, 0);
            if (poke && k == 1) begin
                start = 1'b1; cfg_base = 32'hDEAD0;
            end
            req_grant = g;
            @(negedge clk);
            req_grant = 1'b0; start = 1'b0; cfg_base = b;
            if (g) k++;
            cyc++;
        end
        chk(done && !busy, "R5 done pulse with idle", {done, busy}, 2'b10);
        chk(cur_addr == e, "R5 cur_addr holds last", cur_addr, e);
        @(negedge clk);
        chk(!done && !busy && !req_valid, "R5 done single cycle", {done, busy, req_valid}, 0);
    endtask

    task automatic t_ring();
        logic [31:0] b = 32'h400;
        int area = 12;
        int i;
        launch(b, 0, 3, 3, 1'b0, 1'b1);
        for (i = 0; i < 30; i++) begin
            chk(req_valid && req_addr == b + (i % area), "R6 ring address", req_addr, b + (i % area));
            req_grant = 1'b1;
            @(negedge clk);
            req_grant = 1'b0;
            chk(half_evt == ((i % area) == 5), "R7 half event", half_evt, (i % area) == 5);
            chk(wrap_evt == ((i % area) == 11), "R7 wrap event", wrap_evt, (i % area) == 11);
            chk(busy && !done, "R6 no done in ring", {busy, done}, 2'b10);
        end
        loop_en = 2'b10; req_grant = 1'b1;
        #1;
        chk(!req_valid, "R8 paused no request", req_valid, 0);
        repeat (3) begin
            @(negedge clk);
            chk(cur_addr == b + 6 && !half_evt && !wrap_evt, "R8 paused hold", cur_addr, b + 6);
        end
        loop_en = 2'b11; req_grant = 1'b0;
        #1;
        chk(req_valid && req_addr == b + 6, "R8 resume point", req_addr, b + 6);
        for (i = 30; i < 38; i++) begin
            chk(req_addr == b + (i % area), "R8 R6 after resume", req_addr, b + (i % area));
            req_grant = 1'b1;
            @(negedge clk);
            req_grant = 1'b0;
            chk(wrap_evt == ((i % area) == 11), "R7 wrap after resume", wrap_evt, (i % area) == 11);
        end
        abort = 1'b1; req_grant = 1'b1;
        @(negedge clk);
        abort = 1'b0; req_grant = 1'b0;
        chk(!busy && !done && !req_valid && !half_evt && !wrap_evt, "R9 ring abort",
            {busy, done, req_valid, half_evt, wrap_evt}, 0);
    endtask

    task automatic t_abort();
        launch(32'h50, 4, 8, 1, 1'b0, 1'b0);
        repeat (2) begin
            req_grant = 1'b1;
            @(negedge clk);
        end
        chk(req_addr == 32'h52, "R3 before abort", req_addr, 32'h52);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0; req_grant = 1'b0;
        chk(!busy && !done && !req_valid, "R9 idle after abort", {busy, done, req_valid}, 0);
        chk(cur_addr == 32'h52, "R9 abort beats grant", cur_addr, 32'h52);
        @(negedge clk);
        chk(!done, "R9 no late done", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rect(32'h100, 3, 5, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        t_rect(32'h2000, 1, 4, 3, 1'b0, 1'b1, 1'b1, 1'b1);
        t_ring();
        t_abort();
        t_rect(32'h7000, 4, 4, 0, 1'b1, 1'b1, 1'b1, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule